// File: doc/BRIEF.md
# Prioritized Serial-Port Interrupt Identification

This block sits beside the receive, transmit and modem-control logic of a serial port. It takes five interrupt condition flags, masks each one with its own enable bit, and picks the single most urgent condition that remains. It presents that choice as an identification byte that software reads to decide which service routine to run. It also drives an interrupt request line that is high whenever any enabled condition is pending.

Each condition is cleared by the logic that owns it. The transmit-empty condition is the exception: it is tracked here. It is raised when the holding register becomes empty and withdrawn when the holding register fills again. A status read that reports it also withdraws it. The byte is captured at the first clock edge of a read strobe and held for as long as the strobe stays high, so a condition that arrives during the read cannot change the value being returned. Once a higher condition is serviced, the next read shows the next lower one.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, the status byte reads 0x01 and the interrupt request is low, provided no condition input is high.
- R2: The low nibble names the reported source: line error 0110, receive data at trigger 0100, receive timeout 1100, transmit holding empty 0010, modem status change 0000.
- R3: Priority from highest to lowest is: line error; then receive data; then receive timeout; then transmit empty; then modem change. Receive data and receive timeout share the second level, and receive data wins a tie. Only the highest enabled pending source is reported.
- R4: Bit 0 is 0 while a source is reported and 1 when none is pending; with bit 0 at 1, bits 3:1 read 000.
- R5: Bits 7:6 read 11 when the FIFO-mode input is high and 00 when it is low; bits 5:4 always read 0.
- R6: The enable vector has bit 0 for line error, bit 1 for receive data, bit 2 for receive timeout, bit 3 for transmit empty and bit 4 for modem change. A source whose enable bit is 0 has no effect on the status byte or on the interrupt request.
- R7: The interrupt request is high in exactly the cycles in which at least one enabled source is pending.
- R8: The transmit-empty condition is raised one clock after the holding-empty input rises. It is withdrawn while that input is low.
- R9: A read strobe whose first cycle finds transmit-empty reported withdraws that condition. A read that finds another source reported leaves transmit-empty pending.
- R10: Outside a read, the status byte reflects the inputs one clock later. During a read, it holds the value sampled at the strobe's first edge until the strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO mode indicator |
| en_i | input | 5 | Per-source enables (bit order as in R6) |
| lsr_err_i | input | 1 | Line status error pending |
| rx_trig_i | input | 1 | Receive data at trigger level |
| rx_tmo_i | input | 1 | Receive timeout pending |
| thr_empty_i | input | 1 | Transmit holding register empty (level) |
| msr_chg_i | input | 1 | Modem status changed |
| rd_stb_i | input | 1 | Status read strobe, high for the read's duration |
| stat_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The hardest situation to reach is a read that begins while transmit-empty is reported, with a higher source arriving partway through the strobe. The returned byte must keep showing transmit-empty, that condition must be gone once the strobe falls, and the newly arrived source must appear afterwards. The bench reaches it by raising the holding-empty input alone and waiting until it is reported. It then opens a multi-cycle strobe and raises the line-error input in the strobe's second cycle. After the strobe falls, it drops the line error and checks that nothing lower remains.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC     = 5;
  localparam int CODE_W   = 4;
  localparam int STAT_W   = 8;

  localparam int SRC_LSR  = 0;
  localparam int SRC_RXD  = 1;
  localparam int SRC_RXTO = 2;
  localparam int SRC_THRE = 3;
  localparam int SRC_MSR  = 4;

  localparam logic [STAT_W-1:0] STAT_IDLE = 8'h01;

  // Identification nibble for a source index (index order is priority order)
  function automatic logic [CODE_W-1:0] src_code(input int idx);
    case (idx)
      SRC_LSR:  src_code = 4'b0110;
      SRC_RXD:  src_code = 4'b0100;
      SRC_RXTO: src_code = 4'b1100;
      SRC_THRE: src_code = 4'b0010;
      default:  src_code = 4'b0000;
    endcase
  endfunction

  // Assemble the full status byte
  function automatic logic [STAT_W-1:0] pack_status(input logic fifo,
                                                    input logic any,
                                                    input logic [CODE_W-1:0] code);
    logic [STAT_W-1:0] b;
    b      = '0;
    b[7:6] = {2{fifo}};
    b[3:0] = any ? code : 4'b0001;
    return b;
  endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      pend_i,
  output logic [N-1:0]      grant_o,
  output logic              any_o,
  output logic [CODE_W-1:0] code_o
);
  logic [N:0] block;
  assign block[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_chain
      assign block[gi+1]  = block[gi] | pend_i[gi];
      assign grant_o[gi]  = pend_i[gi] & ~block[gi];
    end
  endgenerate

  assign any_o = block[N];

  always_comb begin
    code_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) code_o = code_o | src_code(i);
    end
  end

  // R3
  onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && (any_o == (grant_o != '0)));

  // R3
  lsr_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_i[SRC_LSR] |-> (code_o == 4'b0110));
endmodule

// File: rtl/irq_thre_track.sv
module irq_thre_track (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_empty_i,
  input  logic clr_i,
  output logic rise_o,
  output logic pend_o
);
  logic thr_d;

  assign rise_o = thr_empty_i & ~thr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_d  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      thr_d <= thr_empty_i;
      if (rise_o)            pend_o <= 1'b1;
      else if (!thr_empty_i) pend_o <= 1'b0;
      else if (clr_i)        pend_o <= 1'b0;
    end
  end

  // R8
  thre_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> pend_o);

  // R9
  thre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !rise_o) |=> !pend_o);
endmodule

// File: rtl/irq_stat_cap.sv
module irq_stat_cap
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb_i,
  input  logic [STAT_W-1:0] live_i,
  output logic              rd_start_o,
  output logic [STAT_W-1:0] stat_o
);
  logic rd_d;
  logic hold;

  assign rd_start_o = rd_stb_i & ~rd_d;
  assign hold       = rd_stb_i & rd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_d   <= 1'b0;
      stat_o <= STAT_IDLE;
    end else begin
      rd_d <= rd_stb_i;
      if (!hold) stat_o <= live_i;
    end
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && !rd_start_o) |=> $stable(stat_o));

  // R4
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[0] |-> (stat_o[3:1] == 3'b000));

  // R5
  unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[5:4] == 2'b00);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en_i,
  input  logic [4:0] en_i,
  input  logic       lsr_err_i,
  input  logic       rx_trig_i,
  input  logic       rx_tmo_i,
  input  logic       thr_empty_i,
  input  logic       msr_chg_i,
  input  logic       rd_stb_i,
  output logic [7:0] stat_o,
  output logic       irq_o
);
  logic              thre_pend;
  logic              thre_rise;
  logic              thre_clr;
  logic              rd_start;
  logic [NSRC-1:0]   raw_pend;
  logic [NSRC-1:0]   masked;
  logic [NSRC-1:0]   grant;
  logic              any_pend;
  logic [CODE_W-1:0] code;
  logic [STAT_W-1:0] live_byte;

  assign raw_pend[SRC_LSR]  = lsr_err_i;
  assign raw_pend[SRC_RXD]  = rx_trig_i;
  assign raw_pend[SRC_RXTO] = rx_tmo_i;
  assign raw_pend[SRC_THRE] = thre_pend;
  assign raw_pend[SRC_MSR]  = msr_chg_i;
  assign masked             = raw_pend & en_i;

  assign thre_clr = rd_start & grant[SRC_THRE];

  irq_thre_track u_thre (
    .clk         (clk),
    .rst_n       (rst_n),
    .thr_empty_i (thr_empty_i),
    .clr_i       (thre_clr),
    .rise_o      (thre_rise),
    .pend_o      (thre_pend)
  );

  irq_prio_enc #(.N(NSRC)) u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_i  (masked),
    .grant_o (grant),
    .any_o   (any_pend),
    .code_o  (code)
  );

  assign live_byte = pack_status(fifo_en_i, any_pend, code);
  assign irq_o     = |masked;

  irq_stat_cap u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_stb_i   (rd_stb_i),
    .live_i     (live_byte),
    .rd_start_o (rd_start),
    .stat_o     (stat_o)
  );

  // R7
  irq_vs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> (stat_o[0] == !$past(irq_o)));

  // R6
  masked_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i[SRC_THRE] |-> !grant[SRC_THRE]);
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en_i = 1'b0;
  logic [4:0] en_i = 5'b0;
  logic       lsr_err_i = 1'b0, rx_trig_i = 1'b0, rx_tmo_i = 1'b0;
  logic       thr_empty_i = 1'b0, msr_chg_i = 1'b0, rd_stb_i = 1'b0;
  logic [7:0] stat_o;
  logic       irq_o;
  int         n_chk = 0;
  int         n_err = 0;

  always #10 clk = ~clk;

  uart_irq_ident u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en_i(fifo_en_i), .en_i(en_i),
    .lsr_err_i(lsr_err_i), .rx_trig_i(rx_trig_i), .rx_tmo_i(rx_tmo_i),
    .thr_empty_i(thr_empty_i), .msr_chg_i(msr_chg_i), .rd_stb_i(rd_stb_i),
    .stat_o(stat_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Expected byte from the requirement text (R2..R5)
  function automatic logic [7:0] exp_byte(input logic fifo, input logic [4:0] p);
    logic [3:0] n;
    if      (p[0]) n = 4'b0110;
    else if (p[1]) n = 4'b0100;
    else if (p[2]) n = 4'b1100;
    else if (p[3]) n = 4'b0010;
    else if (p[4]) n = 4'b0000;
    else           n = 4'b0001;
    return {fifo ? 2'b11 : 2'b00, 2'b00, n};
  endfunction

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_all();
    lsr_err_i = 0; rx_trig_i = 0; rx_tmo_i = 0; msr_chg_i = 0; thr_empty_i = 0;
    settle();
  endtask

  task automatic t_reset();
    chk("R1 reset byte", stat_o, 8'h01);
    chk("R1 reset irq", {7'b0, irq_o}, 8'h00);
  endtask

  task automatic t_codes();
    en_i = 5'b11111;
    for (int f = 0; f < 2; f++) begin
      fifo_en_i = f[0];
      for (int s = 0; s < 5; s++) begin
        lsr_err_i = (s == 0); rx_trig_i = (s == 1); rx_tmo_i = (s == 2);
        thr_empty_i = (s == 3); msr_chg_i = (s == 4);
        settle();
        chk("R2 R5 source code", stat_o, exp_byte(f[0], 5'(1 << s)));
        chk("R7 irq with source", {7'b0, irq_o}, 8'h01);
        clear_all();
      end
      chk("R4 R5 idle byte", stat_o, exp_byte(f[0], 5'b0));
    end
  endtask

  task automatic t_priority();
    logic [4:0] p;
    en_i = 5'b11111; fifo_en_i = 1;
    p = 5'b11111;
    lsr_err_i = 1; rx_trig_i = 1; rx_tmo_i = 1; thr_empty_i = 1; msr_chg_i = 1;
    settle();
    chk("R3 all pending", stat_o, exp_byte(1, p));
    lsr_err_i = 0; p[0] = 0; settle();
    chk("R3 rx data next", stat_o, exp_byte(1, p));
    rx_trig_i = 0; p[1] = 0; settle();
    chk("R3 timeout next", stat_o, exp_byte(1, p));
    rx_tmo_i = 0; p[2] = 0; settle();
    chk("R3 thre next", stat_o, exp_byte(1, p));
    thr_empty_i = 0; p[3] = 0; settle();
    chk("R3 R8 modem last after thre withdrawn", stat_o, exp_byte(1, p));
    clear_all();
  endtask

  task automatic t_mask();
    fifo_en_i = 0;
    en_i = 5'b11110;
    lsr_err_i = 1; msr_chg_i = 1; settle();
    chk("R6 masked line error", stat_o, exp_byte(0, 5'b10000));
    en_i = 5'b01110; settle();
    chk("R6 all masked byte", stat_o, 8'h01);
    chk("R6 R7 all masked irq", {7'b0, irq_o}, 8'h00);
    en_i = 5'b11111; settle();
    chk("R7 irq unmasked", {7'b0, irq_o}, 8'h01);
    clear_all();
  endtask

  task automatic t_thre_read();
    en_i = 5'b11111; fifo_en_i = 1;
    thr_empty_i = 1; settle();
    chk("R8 thre raised", stat_o, 8'hC2);
    rd_stb_i = 1;
    @(negedge clk);
    chk("R10 captured during read", stat_o, 8'hC2);
    lsr_err_i = 1;                     // arrives mid-read
    @(negedge clk);
    chk("R10 held despite new source", stat_o, 8'hC2);
    rd_stb_i = 0;
    @(negedge clk);
    chk("R10 new source after read", stat_o, 8'hC6);
    lsr_err_i = 0; settle();
    chk("R9 thre withdrawn by read", stat_o, 8'hC1);
    chk("R9 irq low after read", {7'b0, irq_o}, 8'h00);
    thr_empty_i = 0; @(negedge clk); thr_empty_i = 1; settle();
    chk("R8 thre raised again", stat_o, 8'hC2);
    clear_all();
  endtask

  task automatic t_read_other();
    en_i = 5'b11111; fifo_en_i = 0;
    thr_empty_i = 1; rx_trig_i = 1; settle();
    chk("R3 rx over thre", stat_o, 8'h04);
    rd_stb_i = 1; repeat (2) @(negedge clk); rd_stb_i = 0;
    rx_trig_i = 0; settle();
    chk("R9 thre kept after other read", stat_o, 8'h02);
    clear_all();
  endtask

  task automatic t_thre_masked_read();
    en_i = 5'b10111; fifo_en_i = 0;
    thr_empty_i = 1; settle();
    chk("R6 masked thre byte", stat_o, 8'h01);
    rd_stb_i = 1; @(negedge clk); rd_stb_i = 0;
    en_i = 5'b11111; settle();
    chk("R9 R6 masked read keeps thre", stat_o, 8'h02);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_codes();
    t_priority();
    t_mask();
    t_thre_read();
    t_read_other();
    t_thre_masked_read();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule